// File: doc/BRIEF.md
# Vectored Interrupt Collector

This block merges a bank of level-sensitive interrupt sources into a single interrupt line for a processor. Each source has its own small control word that holds an enable and a two-bit priority level. The block keeps one in-service flag per level. A source can be presented only when its raw input is high, it is enabled, and its level is not in service. Among the sources that qualify, the lowest-numbered one is presented. Its number is visible in a status word.

Software uses a simple synchronous register port. Every register slot is 16 bytes wide, and address bits [3:2] select how a write is applied:
- 0 replaces the value.
- 1 ORs the data in.
- 2 clears the bits that are set in the data.
- 3 toggles them.

Reads return the same value through every alias. The port never stalls: a write takes effect at the clock edge on which it is presented. A read returns its data, marked by `rvalid_o`, one cycle later. There is no back-pressure.

Servicing works as follows. Software reads the status word, then takes the interrupt by writing the source number to the vector register. This marks the presented source's level as in service. Software ends servicing by writing a one for that level to the level-acknowledge register. A source that is still asserted is then presented again.

Top module: `icoll_top`

## Requirements
- R1: For the vector, control and per-source registers, the address alias selected by bits [3:2] applies write data as follows: 0 replaces, 1 ORs in, 2 clears written ones, 3 toggles written ones. A read through any alias returns the plain value.
- R2: The control word for source n lives at byte offset 0x120 + 16*n. Bit 2 is the enable and bits [1:0] are the level. Every other bit reads 0, and all fields reset to 0.
- R3: `irq_o` is high in the cycle after a clock edge at which some source was raw-high, enabled and at a level not in service. Otherwise it is low.
- R4: The status word at offset 0x70 reads bit 31 = a source is being presented, and bits [6:0] = the lowest-numbered such source. It reads 0 when no source is presented.
- R5: A write to the vector register at offset 0x000 stores a 7-bit value. If a source is being presented at that edge, the write also marks that source's level in service, and sources at that level stop being presented.
- R6: A write to the level-acknowledge register at offset 0x10, through any alias, clears the in-service flag of each level k whose data bit k is 1. Reads of this register return the in-service flags in bits [3:0].
- R7: A source that is still asserted and enabled is presented again once its level has been acknowledged.
- R8: Writing bit 31 of the control register at offset 0x20 starts a soft reset. In the next cycle the bit reads 1. At the following edge the block clears every enable, level, in-service flag and the vector, and bit 31 returns to 0. A bus write that falls in that clearing cycle is discarded.
- R9: A read returns its data with `rvalid_o` exactly one cycle later. Unmapped offsets read 0, and writes to the status word are ignored.
- R10: While one level is in service, enabled sources at other levels are still presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 128 | Raw level-sensitive interrupt sources |
| wr_en_i | input | 1 | Write strobe for the register port |
| rd_en_i | input | 1 | Read strobe for the register port |
| addr_i | input | 12 | Byte address; [11:4] selects the slot, [3:2] the alias |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid when rvalid_o is high |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| irq_o | output | 1 | Combined interrupt line to the processor |

## Verification
Two functions can fall in the same cycle: the clearing cycle of a soft reset and an ordinary register write. The bench provokes this by issuing a control-register write with bit 31 set and, on the very next cycle, a write that enables a source. It judges the result by reading that source's control word back as 0 and by watching `irq_o` stay low. A second overlap is a level acknowledge that lands while the same source is still asserted. Here the bench expects the source to come back in the status word two cycles later. A behavioural reference model checks the line and every read response on each clock.

// File: rtl/icoll_pkg.sv
package icoll_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int SLOT_W    = 8;
  localparam int LVL_W     = 2;
  localparam int NUM_LVL   = 1 << LVL_W;
  localparam int EN_BIT    = 2;
  localparam int FLAG_BIT  = 31;

  localparam logic [SLOT_W-1:0] SLOT_VEC  = 8'h00;
  localparam logic [SLOT_W-1:0] SLOT_ACK  = 8'h01;
  localparam logic [SLOT_W-1:0] SLOT_CTRL = 8'h02;
  localparam logic [SLOT_W-1:0] SLOT_STAT = 8'h07;
  localparam logic [SLOT_W-1:0] SLOT_SRC0 = 8'h12;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  function automatic logic [DATA_W-1:0] apply_alias(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] wd,
    input alias_op_e         op
  );
    logic [DATA_W-1:0] res;
    case (op)
      OP_SET:  res = cur | wd;
      OP_CLR:  res = cur & ~wd;
      OP_TOG:  res = cur ^ wd;
      default: res = wd;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/icoll_src_bank.sv
module icoll_src_bank
  import icoll_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr_all_i,
  input  logic                            wr_hit_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [EN_BIT:0]                 wr_val_i,
  output logic [NUM_SRC-1:0]              en_o,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [EN_BIT:0] cfg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (clr_all_i) begin
        cfg_q <= '0;
      end else if (wr_hit_i && (wr_idx_i == IDX_W'(g))) begin
        cfg_q <= wr_val_i;
      end
    end
    assign en_o[g]  = cfg_q[EN_BIT];
    assign lvl_o[g] = cfg_q[LVL_W-1:0];
  end
endmodule

// File: rtl/icoll_arbiter.sv
module icoll_arbiter #(
  parameter int NUM_REQ = 128,
  parameter int IDX_W   = $clog2(NUM_REQ)
) (
  input  logic [NUM_REQ-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/icoll_service.sv
module icoll_service
  import icoll_pkg::*;
#(
  parameter int VEC_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all_i,
  input  logic               vec_wr_i,
  input  logic [VEC_W-1:0]   vec_val_i,
  input  logic               take_i,
  input  logic [LVL_W-1:0]   take_lvl_i,
  input  logic               ack_i,
  input  logic [NUM_LVL-1:0] ack_mask_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NUM_LVL-1:0] insvc_o
);
  logic [NUM_LVL-1:0] insvc_d;

  always_comb begin
    insvc_d = insvc_o;
    if (ack_i) insvc_d = insvc_d & ~ack_mask_i;
    if (take_i) insvc_d[take_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insvc_o <= '0;
      vec_o   <= '0;
    end else if (clr_all_i) begin
      insvc_o <= '0;
      vec_o   <= '0;
    end else begin
      insvc_o <= insvc_d;
      if (vec_wr_i) vec_o <= vec_val_i;
    end
  end
endmodule

// File: rtl/icoll_top.sv
module icoll_top
  import icoll_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o,
  output logic               irq_o
);
  localparam int ID_W = $clog2(NUM_SRC);

  logic [SLOT_W-1:0]            slot;
  alias_op_e                    op;
  logic [SLOT_W-1:0]            src_off;
  logic                         src_hit;
  logic [ID_W-1:0]              src_idx;
  logic [DATA_W-1:0]            cur_word;
  logic [DATA_W-1:0]            new_word;
  logic                         wr_ok;
  logic                         rst_pend;
  logic [NUM_SRC-1:0]           en;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic [NUM_LVL-1:0]           insvc;
  logic [ID_W-1:0]              vec_q;
  logic [NUM_SRC-1:0]           elig;
  logic                         arb_any;
  logic [ID_W-1:0]              arb_idx;
  logic                         pres_v;
  logic [ID_W-1:0]              pres_id;
  logic                         take;
  logic [LVL_W-1:0]             take_lvl;
  logic                         unused_bits;

  assign slot    = addr_i[ADDR_W-1:4];
  assign op      = alias_op_e'(addr_i[3:2]);
  assign src_off = slot - SLOT_SRC0;
  assign src_hit = (slot >= SLOT_SRC0) && (src_off < SLOT_W'(NUM_SRC));
  assign src_idx = src_off[ID_W-1:0];

  always_comb begin
    cur_word = '0;
    case (slot)
      SLOT_VEC:  cur_word[ID_W-1:0]    = vec_q;
      SLOT_ACK:  cur_word[NUM_LVL-1:0] = insvc;
      SLOT_CTRL: cur_word[FLAG_BIT]    = rst_pend;
      SLOT_STAT: begin
        cur_word[FLAG_BIT]  = pres_v;
        cur_word[ID_W-1:0]  = pres_id;
      end
      default: begin
        if (src_hit) begin
          cur_word[EN_BIT]      = en[src_idx];
          cur_word[LVL_W-1:0]   = lvl[src_idx];
        end
      end
    endcase
  end

  assign new_word = apply_alias(cur_word, wdata_i, op);
  assign wr_ok    = wr_en_i && !rst_pend;
  assign take     = wr_ok && (slot == SLOT_VEC) && pres_v;
  assign take_lvl = lvl[pres_id];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 rst_pend <= 1'b0;
    else if (rst_pend)                          rst_pend <= 1'b0;
    else if (wr_ok && (slot == SLOT_CTRL))      rst_pend <= new_word[FLAG_BIT];
  end

  icoll_src_bank #(.NUM_SRC(NUM_SRC), .IDX_W(ID_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all_i (rst_pend),
    .wr_hit_i  (wr_ok && src_hit),
    .wr_idx_i  (src_idx),
    .wr_val_i  (new_word[EN_BIT:0]),
    .en_o      (en),
    .lvl_o     (lvl)
  );

  icoll_service #(.VEC_W(ID_W)) u_svc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all_i  (rst_pend),
    .vec_wr_i   (wr_ok && (slot == SLOT_VEC)),
    .vec_val_i  (new_word[ID_W-1:0]),
    .take_i     (take),
    .take_lvl_i (take_lvl),
    .ack_i      (wr_ok && (slot == SLOT_ACK)),
    .ack_mask_i (wdata_i[NUM_LVL-1:0]),
    .vec_o      (vec_q),
    .insvc_o    (insvc)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = src_i[g] & en[g] & ~insvc[lvl[g]];
  end

  icoll_arbiter #(.NUM_REQ(NUM_SRC), .IDX_W(ID_W)) u_arb (
    .req_i (elig),
    .any_o (arb_any),
    .idx_o (arb_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_v   <= 1'b0;
      pres_id  <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      pres_v   <= arb_any;
      pres_id  <= arb_idx;
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= cur_word;
    end
  end

  assign irq_o = pres_v;

  assign unused_bits = ^{addr_i[1:0], new_word, src_off};
endmodule

// File: rtl/icoll_chk.sv
module icoll_chk
  import icoll_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [SLOT_W-1:0]  slot_i,
  input logic [NUM_LVL-1:0] ack_bits_i,
  input logic               rvalid_o,
  input logic               irq_o,
  input logic               rst_pend,
  input logic [NUM_LVL-1:0] insvc,
  input logic [ID_W-1:0]    pres_id,
  input logic               take,
  input logic [LVL_W-1:0]   take_lvl
);
  logic [NUM_SRC-1:0] src_d;
  logic [LVL_W-1:0]   take_lvl_d;
  logic [NUM_LVL-1:0] ack_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d      <= '0;
      take_lvl_d <= '0;
      ack_d      <= '0;
    end else begin
      src_d      <= src_i;
      take_lvl_d <= take_lvl;
      ack_d      <= ack_bits_i;
    end
  end

  // R9
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rvalid_o);
  // R9
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rvalid_o);
  // R8
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |=> (insvc == '0) && !rst_pend);
  // R5
  take_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> insvc[take_lvl_d]);
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !rst_pend && slot_i == SLOT_ACK) |=> ((insvc & ack_d) == '0));
  // R3
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> src_d[pres_id]);
endmodule

bind icoll_top icoll_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_i      (src_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .slot_i     (addr_i[11:4]),
  .ack_bits_i (wdata_i[3:0]),
  .rvalid_o   (rvalid_o),
  .irq_o      (irq_o),
  .rst_pend   (rst_pend),
  .insvc      (insvc),
  .pres_id    (pres_id),
  .take       (take),
  .take_lvl   (take_lvl)
);

// File: tb/icoll_top_bench.sv
`timescale 1ns/1ps
module icoll_top_bench;
  localparam int NS = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  icoll_top u_icoll_top (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq)
  );

  // behavioural reference model
  bit          m_en [NS];
  int          m_lvl [NS];
  bit [3:0]    m_svc;
  int          m_vec;
  bit          m_pend;
  bit          m_pv;
  int          m_pid;
  bit          m_rvalid;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_alias(logic [31:0] o, logic [31:0] w, int k);
    if (k == 1) return o | w;
    if (k == 2) return o & ~w;
    if (k == 3) return o ^ w;
    return w;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    int s;
    s = int'(a[11:4]);
    if (s == 0) return 32'(m_vec);
    if (s == 1) return {28'd0, m_svc};
    if (s == 2) return {m_pend, 31'd0};
    if (s == 7) return m_pv ? (32'h8000_0000 | 32'(m_pid)) : 32'd0;
    if (s >= 18 && s < 18 + NS) return 32'((m_en[s-18] ? 4 : 0) + m_lvl[s-18]);
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin m_en[i] = 0; m_lvl[i] = 0; end
      m_svc = 0; m_vec = 0; m_pend = 0; m_pv = 0; m_pid = 0;
      m_rvalid = 0; m_rdata = 0;
    end else begin
      bit found; int id; logic [31:0] rv; int s; int k; logic [31:0] nv;
      found = 0; id = 0;
      for (int i = 0; i < NS; i++)
        if (!found && src[i] && m_en[i] && !m_svc[m_lvl[i]]) begin found = 1; id = i; end
      rv = m_read(addr);
      s = int'(addr[11:4]);
      k = int'(addr[3:2]);
      nv = m_alias(m_read(addr), wdata, k);
      if (m_pend) begin
        for (int i = 0; i < NS; i++) begin m_en[i] = 0; m_lvl[i] = 0; end
        m_svc = 0; m_vec = 0; m_pend = 0;
      end else if (wr_en) begin
        if (s == 0) begin
          m_vec = int'(nv[6:0]);
          if (m_pv) m_svc[m_lvl[m_pid]] = 1'b1;
        end else if (s == 1) begin
          m_svc = m_svc & ~wdata[3:0];
        end else if (s == 2) begin
          m_pend = nv[31];
        end else if (s >= 18 && s < 18 + NS) begin
          m_en[s-18]  = nv[2];
          m_lvl[s-18] = int'(nv[1:0]);
        end
      end
      m_pv = found; m_pid = id;
      m_rvalid = rd_en;
      if (rd_en) m_rdata = rv;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_pv) begin
        fails++;
        $display("FAIL R3 irq_o=%0b expected=%0b", irq, m_pv);
      end
      checks++;
      if (rvalid !== m_rvalid || (m_rvalid && rdata !== m_rdata)) begin
        fails++;
        $display("FAIL R9 rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                 rvalid, rdata, m_rvalid, m_rdata);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h rdata=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq_o=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // reset state
    rd_chk(12'h120, 32'd0, "R2");
    rd_chk(12'h070, 32'd0, "R4");
    rd_chk(12'h000, 32'd0, "R5");
    irq_chk(1'b0, "R3");
    // field masking and aliases on source 5
    wr(12'h170, 32'hFFFF_FFFA);
    rd_chk(12'h170, 32'd2, "R2");
    rd_chk(12'h178, 32'd2, "R1");
    rd_chk(12'h17C, 32'd2, "R1");
    wr(12'h174, 32'd4);
    wr(12'h178, 32'd2);
    wr(12'h17C, 32'd5);
    rd_chk(12'h170, 32'd1, "R1");
    wr(12'h17C, 32'd5);
    rd_chk(12'h170, 32'd4, "R1");
    // presentation
    src[5] = 1'b1;
    idle(2);
    irq_chk(1'b1, "R3");
    rd_chk(12'h070, 32'h8000_0005, "R4");
    wr(12'h150, 32'd5);
    src[3] = 1'b1;
    idle(2);
    rd_chk(12'h070, 32'h8000_0003, "R4");
    // take source 3 (level 1)
    wr(12'h000, 32'd3);
    idle(2);
    rd_chk(12'h010, 32'd2, "R5");
    rd_chk(12'h070, 32'h8000_0005, "R10");
    rd_chk(12'h000, 32'd3, "R5");
    // take source 5 (level 0)
    wr(12'h000, 32'd5);
    idle(2);
    irq_chk(1'b0, "R5");
    rd_chk(12'h070, 32'd0, "R5");
    // acknowledge level 0 through the set alias
    wr(12'h014, 32'd1);
    idle(2);
    rd_chk(12'h070, 32'h8000_0005, "R7");
    rd_chk(12'h010, 32'd2, "R6");
    wr(12'h010, 32'd2);
    idle(2);
    rd_chk(12'h070, 32'h8000_0003, "R6");
    rd_chk(12'h010, 32'd0, "R6");
    // unmapped and read-only
    rd_chk(12'h040, 32'd0, "R9");
    rd_chk(12'h920, 32'd0, "R9");
    wr(12'h070, 32'hFFFF_FFFF);
    idle(1);
    rd_chk(12'h070, 32'h8000_0003, "R9");
    // soft reset with read-back
    wr(12'h024, 32'h8000_0000);
    rd_chk(12'h020, 32'h8000_0000, "R8");
    idle(2);
    rd_chk(12'h020, 32'd0, "R8");
    rd_chk(12'h170, 32'd0, "R8");
    rd_chk(12'h150, 32'd0, "R8");
    rd_chk(12'h000, 32'd0, "R8");
    irq_chk(1'b0, "R8");
    // soft reset colliding with a write in the clearing cycle
    wr(12'h170, 32'd4);
    idle(2);
    irq_chk(1'b1, "R3");
    wr(12'h020, 32'h8000_0000);
    wr(12'h190, 32'd4);
    idle(2);
    rd_chk(12'h190, 32'd0, "R8");
    rd_chk(12'h170, 32'd0, "R8");
    irq_chk(1'b0, "R8");
    idle(2);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule